// File: doc/BRIEF.md
# Seven-Channel DMA Control Register Bank

This block is the register bank that software uses to program a seven-channel DMA engine. It decodes a 7-bit byte offset and handles byte, halfword and word accesses. Each channel has three registers: a 24-bit start address, a block-control word (word count and block count), and a channel-control word. The control word appears at two adjacent offsets. The top slot of the window holds the shared registers: a priority and enable word, an interrupt control word, and two read-only constants.

The stored fields go straight to the transfer engine on flat output buses. A write to a channel's control word also sends that channel a one-cycle restart pulse, which returns the engine to waiting and clears its chain length. The engine reports a finished transfer with a per-channel completion pulse. That pulse latches an interrupt flag, and software clears the flag by writing one to it. A single interrupt line pulses whenever the combined master flag rises. Channel 6 is the ordering-table channel: the hardware overrides most of its control fields.

Top module: `dma_csr_bank`

## Requirements
- R1: Offset map. Bits 6:4 select the slot, and slots 0 to 6 belong to channels 0 to 6. Within a channel slot, bits 3:2 select the register: 0 is the start address, 1 is block control, and both 2 and 3 are the same channel-control register. Slot 7 holds the shared registers, with bits 3:2 selecting priority (0), interrupt (1), constant A (2) and constant B (3).
- R2: The start address keeps only bits 23:0 and reads zero above them. Block control reads back all 32 bits: word count in 15:0, block count in 31:16. The stored values appear on the flat output buses, 24 or 32 bits per channel, with channel 0 in the lowest bits.
- R3: Channel control stores bits 0, 1, 2, 10:9, 18:16, 22:20, 24, 28 and 30:29. All other bits read zero.
- R4: The priority word stores bits 27:0 and reads zero above them. Each channel uses four bits starting at 4*n: a 3-bit priority, then an enable bit at 4*n+3. These appear on the chanPrio and chanMasterEn outputs.
- R5: Interrupt word layout:
  - bits 5:0: scratch that reads back as written
  - bit 15: force; can be written, reads zero
  - bits 22:16: per-channel enables
  - bit 23: master enable
  - bits 30:24: per-channel flags
  - bit 31: master flag; read only
- R6: Writing 1 to flag bit 24+n clears flag n. Writing 0 there leaves the flag unchanged.
- R7: Constant A reads 0x7FE358D1 and constant B reads 0x00FFFFF7. Writes to either offset change no register.
- R8: Any write to channel 6's control register stores bits 24, 28 and 30 as written, forces bit 1 to 1, and forces every other field to 0.
- R9: A control-register write to channel n makes chanRestart equal to (1 << n) for exactly the next cycle. chanRestart is zero otherwise.
- R10: accSize encodes 0 as byte, 1 as halfword, and 2 or 3 as word. Byte and halfword writes to block control change only the addressed byte or halfword. Sub-word reads of block control return only the addressed bytes, right-aligned.
- R11: A sub-word write to any other register shifts the data left by 8 times offset bits 1:0 and is then applied as a full word write, so the other bytes become zero. A sub-word read returns the word shifted right by the same amount, with no mask.
- R12: A completion pulse on channel n sets flag n only when enable n was 1 before that clock edge. If the flag is set and cleared in the same cycle, the set wins.
- R13: Master flag = force OR (master enable AND the OR over all n of (enable n AND flag n)). irqOut is high for one cycle after each clock edge at which the master flag goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accAddr | input | 7 | Byte offset of the access |
| accSize | input | 2 | Access width: 0 byte, 1 halfword, 2 or 3 word |
| accWr | input | 1 | Write strobe, applied at the clock edge |
| accWdata | input | 32 | Write data, right-aligned |
| accRdata | output | 32 | Combinational read data for accAddr and accSize |
| chanDone | input | 7 | Per-channel completion pulses |
| chanRestart | output | 7 | Per-channel restart pulse after a control write |
| baseAddrFlat | output | 168 | Start addresses, 24 bits per channel |
| blockCtrlFlat | output | 224 | Block-control words, 32 bits per channel |
| chanCtrlFlat | output | 224 | Channel-control words, 32 bits per channel |
| chanPrio | output | 21 | Priorities, 3 bits per channel |
| chanMasterEn | output | 7 | Per-channel enable bits from the priority word |
| irqOut | output | 1 | Interrupt pulse on a rising master flag |

## Verification
Assertions check several rules on every cycle:
- A flag only rises after an enabled completion.
- A write-one-to-clear leaves the targeted flag low unless a completion arrives in the same cycle.
- Every control write is followed by a restart pulse, and the restart vector never has more than one bit set.
- Channel 6's decrement bit reads 1 after its control register is written.
- irqOut never stays high for two cycles in a row.
- A write to a constant offset leaves the shared registers unchanged.

Only the bench scenarios can show the byte-lane behaviour: which bytes a sub-word block-control write keeps, and how a sub-word write elsewhere zeroes the other bytes. The same holds for the mirrored control offset, the exact constants, and the timing of an interrupt pulse relative to a forced or enabled flag.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int CH_IDX_W = 3;
  localparam logic [31:0] CONST_A      = 32'h7FE3_58D1;
  localparam logic [31:0] CONST_B      = 32'h00FF_FFF7;
  localparam logic [31:0] CTRL_KEEP    = 32'h7177_0607;
  localparam logic [31:0] ORDER_KEEP   = 32'h5100_0000;
  localparam logic [31:0] ORDER_FORCE1 = 32'h0000_0002;

  typedef enum logic [2:0] {
    SEL_BASE, SEL_BLOCK, SEL_CTRL, SEL_PRIO, SEL_IRQ, SEL_KA, SEL_KB
  } regSel_t;

  // strobes passed from the decoder to the register datapath
  typedef struct packed {
    regSel_t               sel;
    logic [CH_IDX_W-1:0]   chan;
    logic                  wrStb;
    logic [1:0]            lane;
    logic [3:0]            laneMask;
    logic [31:0]           laneData;
    logic [31:0]           rdMask;
  } csrStrobe_t;
endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic              accWr,
  input  logic [31:0]       accWdata,
  output csrStrobe_t        stb
);
  localparam int SLOT_LSB = 4;
  localparam logic [CH_IDX_W-1:0] SHARED_SLOT = '1;

  logic       wordAcc;
  logic [4:0] shAmt;
  logic [3:0] subMask;
  logic [31:0] subRdMask;

  always_comb begin
    wordAcc      = accSize[1];
    stb.wrStb    = accWr;
    stb.chan     = accAddr[SLOT_LSB +: CH_IDX_W];
    stb.lane     = wordAcc ? 2'd0 : accAddr[1:0];
    shAmt        = {stb.lane, 3'b000};
    stb.laneData = accWdata << shAmt;

    if (wordAcc) begin
      subMask   = 4'b1111;
      subRdMask = 32'hFFFF_FFFF;
    end else if (accSize[0]) begin
      subMask   = 4'b0011 << accAddr[1:0];
      subRdMask = 32'h0000_FFFF;
    end else begin
      subMask   = 4'b0001 << accAddr[1:0];
      subRdMask = 32'h0000_00FF;
    end
    stb.laneMask = subMask;

    if (stb.chan == SHARED_SLOT) begin
      case (accAddr[3:2])
        2'd0:    stb.sel = SEL_PRIO;
        2'd1:    stb.sel = SEL_IRQ;
        2'd2:    stb.sel = SEL_KA;
        default: stb.sel = SEL_KB;
      endcase
    end else begin
      case (accAddr[3:2])
        2'd0:    stb.sel = SEL_BASE;
        2'd1:    stb.sel = SEL_BLOCK;
        default: stb.sel = SEL_CTRL;
      endcase
    end
    stb.rdMask = (stb.sel == SEL_BLOCK) ? subRdMask : 32'hFFFF_FFFF;
  end
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH   = 7,
  parameter int BASE_W   = 24,
  parameter int ORDER_CH = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  csrStrobe_t               stb,
  input  logic [NUM_CH-1:0]        chanDone,
  output logic [31:0]              accRdata,
  output logic [NUM_CH-1:0]        chanRestart,
  output logic [NUM_CH*BASE_W-1:0] baseAddrFlat,
  output logic [NUM_CH*32-1:0]     blockCtrlFlat,
  output logic [NUM_CH*32-1:0]     chanCtrlFlat,
  output logic [NUM_CH*3-1:0]      chanPrio,
  output logic [NUM_CH-1:0]        chanMasterEn,
  output logic                     irqOut
);
  localparam int PRIO_W  = NUM_CH * 4;
  localparam int EN_LSB  = 16;
  localparam int FLG_LSB = 24;

  // per-channel registers
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic              hitCh;
    logic [BASE_W-1:0] baseQ;
    logic [31:0]       blkQ;
    logic [31:0]       ctlQ;
    logic              restartQ;

    assign hitCh = stb.wrStb && (stb.chan == CH_IDX_W'(n));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ    <= '0;
        blkQ     <= '0;
        ctlQ     <= '0;
        restartQ <= 1'b0;
      end else begin
        restartQ <= 1'b0;
        if (hitCh) begin
          case (stb.sel)
            SEL_BASE:  baseQ <= stb.laneData[BASE_W-1:0];
            SEL_BLOCK: begin
              for (int b = 0; b < 4; b++)
                if (stb.laneMask[b]) blkQ[b*8 +: 8] <= stb.laneData[b*8 +: 8];
            end
            SEL_CTRL: begin
              if (n == ORDER_CH) ctlQ <= (stb.laneData & ORDER_KEEP) | ORDER_FORCE1;
              else               ctlQ <= stb.laneData & CTRL_KEEP;
              restartQ <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end

    assign baseAddrFlat[n*BASE_W +: BASE_W] = baseQ;
    assign blockCtrlFlat[n*32 +: 32]        = blkQ;
    assign chanCtrlFlat[n*32 +: 32]         = ctlQ;
    assign chanRestart[n]                   = restartQ;
  end

  // shared priority word
  logic [PRIO_W-1:0] prioQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prioQ <= '0;
    else if (stb.wrStb && stb.sel == SEL_PRIO) prioQ <= stb.laneData[PRIO_W-1:0];
  end
  for (genvar n = 0; n < NUM_CH; n++) begin : g_prio
    assign chanPrio[n*3 +: 3] = prioQ[n*4 +: 3];
    assign chanMasterEn[n]    = prioQ[n*4 + 3];
  end

  // interrupt word
  logic [5:0]        scratchQ;
  logic              forceQ, menQ, masterQ, masterFlag, wrIrq;
  logic [NUM_CH-1:0] enQ, flagQ, clrVec, setVec;

  assign wrIrq  = stb.wrStb && (stb.sel == SEL_IRQ);
  assign clrVec = wrIrq ? stb.laneData[FLG_LSB +: NUM_CH] : '0;
  assign setVec = chanDone & enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scratchQ <= '0;
      forceQ   <= 1'b0;
      menQ     <= 1'b0;
      enQ      <= '0;
      flagQ    <= '0;
      masterQ  <= 1'b0;
    end else begin
      flagQ   <= (flagQ & ~clrVec) | setVec;
      masterQ <= masterFlag;
      if (wrIrq) begin
        scratchQ <= stb.laneData[5:0];
        forceQ   <= stb.laneData[15];
        enQ      <= stb.laneData[EN_LSB +: NUM_CH];
        menQ     <= stb.laneData[EN_LSB + NUM_CH];
      end
    end
  end

  assign masterFlag = forceQ | (menQ & |(enQ & flagQ));
  assign irqOut     = masterFlag & ~masterQ;

  // read path
  logic [CH_IDX_W-1:0] chanIdx;
  logic [31:0]         rdWord;
  assign chanIdx = (stb.chan < CH_IDX_W'(NUM_CH)) ? stb.chan : '0;

  always_comb begin
    rdWord = '0;
    case (stb.sel)
      SEL_BASE:  rdWord[BASE_W-1:0] = baseAddrFlat[chanIdx*BASE_W +: BASE_W];
      SEL_BLOCK: rdWord = blockCtrlFlat[chanIdx*32 +: 32];
      SEL_CTRL:  rdWord = chanCtrlFlat[chanIdx*32 +: 32];
      SEL_PRIO:  rdWord[PRIO_W-1:0] = prioQ;
      SEL_IRQ: begin
        rdWord[5:0]                = scratchQ;
        rdWord[EN_LSB +: NUM_CH]   = enQ;
        rdWord[EN_LSB + NUM_CH]    = menQ;
        rdWord[FLG_LSB +: NUM_CH]  = flagQ;
        rdWord[31]                 = masterFlag;
      end
      SEL_KA:    rdWord = CONST_A;
      default:   rdWord = CONST_B;
    endcase
    accRdata = (rdWord >> {stb.lane, 3'b000}) & stb.rdMask;
  end

  // assertions
  AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & ~$past(flagQ)) & ~$past(chanDone & enQ)) == '0);  // R12
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wrIrq |=> (flagQ & $past(clrVec & ~setVec)) == '0);  // R6
  AST_RESTART_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanRestart));  // R9
  AST_RESTART_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && stb.sel == SEL_CTRL) |=> chanRestart != '0);  // R9
  AST_ORDER_DEC_SET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && stb.sel == SEL_CTRL && stb.chan == CH_IDX_W'(ORDER_CH))
      |=> chanCtrlFlat[ORDER_CH*32 + 1]);  // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> !irqOut);  // R13
  AST_CONST_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && (stb.sel == SEL_KA || stb.sel == SEL_KB))
      |=> $stable(prioQ) && $stable({enQ, menQ, scratchQ, forceQ}));  // R7
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH   = 7,
  parameter int ADDR_W   = 7,
  parameter int BASE_W   = 24,
  parameter int ORDER_CH = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        accAddr,
  input  logic [1:0]               accSize,
  input  logic                     accWr,
  input  logic [31:0]              accWdata,
  output logic [31:0]              accRdata,
  input  logic [NUM_CH-1:0]        chanDone,
  output logic [NUM_CH-1:0]        chanRestart,
  output logic [NUM_CH*BASE_W-1:0] baseAddrFlat,
  output logic [NUM_CH*32-1:0]     blockCtrlFlat,
  output logic [NUM_CH*32-1:0]     chanCtrlFlat,
  output logic [NUM_CH*3-1:0]      chanPrio,
  output logic [NUM_CH-1:0]        chanMasterEn,
  output logic                     irqOut
);
  csrStrobe_t stb;

  dma_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .accAddr (accAddr),
    .accSize (accSize),
    .accWr   (accWr),
    .accWdata(accWdata),
    .stb     (stb)
  );

  dma_csr_regs #(.NUM_CH(NUM_CH), .BASE_W(BASE_W), .ORDER_CH(ORDER_CH)) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .chanDone     (chanDone),
    .accRdata     (accRdata),
    .chanRestart  (chanRestart),
    .baseAddrFlat (baseAddrFlat),
    .blockCtrlFlat(blockCtrlFlat),
    .chanCtrlFlat (chanCtrlFlat),
    .chanPrio     (chanPrio),
    .chanMasterEn (chanMasterEn),
    .irqOut       (irqOut)
  );
endmodule

// File: tb/sim_dma_csr_bank.sv
`timescale 1ns/1ps
module sim_dma_csr_bank;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [6:0]   accAddr = '0;
  logic [1:0]   accSize = 2'd2;
  logic         accWr = 1'b0;
  logic [31:0]  accWdata = '0;
  logic [31:0]  accRdata;
  logic [6:0]   chanDone = '0;
  logic [6:0]   chanRestart;
  logic [167:0] baseAddrFlat;
  logic [223:0] blockCtrlFlat, chanCtrlFlat;
  logic [20:0]  chanPrio;
  logic [6:0]   chanMasterEn;
  logic         irqOut;

  int checks = 0;
  int fails  = 0;
  string curTag = "R1";

  always #4 clk = ~clk;  // 125 MHz

  dma_csr_bank u0 (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .accSize(accSize), .accWr(accWr),
    .accWdata(accWdata), .accRdata(accRdata), .chanDone(chanDone),
    .chanRestart(chanRestart), .baseAddrFlat(baseAddrFlat),
    .blockCtrlFlat(blockCtrlFlat), .chanCtrlFlat(chanCtrlFlat),
    .chanPrio(chanPrio), .chanMasterEn(chanMasterEn), .irqOut(irqOut)
  );

  // behavioural reference state
  logic [31:0] mBase[7], mBlk[7], mCtl[7];
  logic [31:0] mPrio;
  logic [5:0]  mScr;
  logic        mForce, mMen, mMfPrev;
  logic [6:0]  mEn, mFlag, mRestart;

  function automatic logic mMaster();
    return mForce | (mMen & |(mEn & mFlag));
  endfunction

  function automatic logic [31:0] mRead(logic [6:0] a, logic [1:0] sz);
    logic [31:0] w;
    int slot = int'(a[6:4]);
    int sh = sz[1] ? 0 : int'(a[1:0]);
    if (slot == 7) begin
      case (a[3:2])
        2'd0: w = mPrio;
        2'd1: w = {mMaster(), mFlag, mMen, mEn, 10'b0, mScr};
        2'd2: w = 32'h7FE3_58D1;
        default: w = 32'h00FF_FFF7;
      endcase
    end else begin
      case (a[3:2])
        2'd0: w = mBase[slot];
        2'd1: w = mBlk[slot];
        default: w = mCtl[slot];
      endcase
    end
    w = w >> (8 * sh);
    if (slot != 7 && a[3:2] == 2'd1 && !sz[1]) w = w & (sz[0] ? 32'hFFFF : 32'hFF);
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < 7; n++) begin mBase[n] = 0; mBlk[n] = 0; mCtl[n] = 0; end
      mPrio = 0; mScr = 0; mForce = 0; mMen = 0; mEn = 0; mFlag = 0;
      mMfPrev = 0; mRestart = 0;
    end else begin
      logic [6:0]  setv, clrv;
      logic [31:0] d;
      int slot, sh;
      mMfPrev  = mMaster();
      mRestart = 0;
      setv = chanDone & mEn;
      clrv = 0;
      if (accWr) begin
        slot = int'(accAddr[6:4]);
        sh = accSize[1] ? 0 : int'(accAddr[1:0]);
        d = accWdata << (8 * sh);
        if (slot == 7) begin
          if (accAddr[3:2] == 2'd0) mPrio = d & 32'h0FFF_FFFF;
          else if (accAddr[3:2] == 2'd1) begin
            mScr = d[5:0]; mForce = d[15]; mEn = d[22:16]; mMen = d[23]; clrv = d[30:24];
          end
        end else if (accAddr[3:2] == 2'd0) mBase[slot] = d & 32'h00FF_FFFF;
        else if (accAddr[3:2] == 2'd1) begin
          if (accSize[1]) mBlk[slot] = d;
          else if (accSize[0]) mBlk[slot][8*sh +: 16] = d[8*sh +: 16];
          else mBlk[slot][8*sh +: 8] = d[8*sh +: 8];
        end else begin
          if (slot == 6) mCtl[slot] = (d & 32'h5100_0000) | 32'h2;
          else mCtl[slot] = d & 32'h7177_0607;
          mRestart[slot] = 1'b1;
        end
      end
      mFlag = (mFlag & ~clrv) | setv;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the reference on every clock
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      check(curTag, accRdata, mRead(accAddr, accSize));
      check("R13", {31'b0, irqOut}, {31'b0, mMaster() & ~mMfPrev});
      check("R9", {25'b0, chanRestart}, {25'b0, mRestart});
      check("R4", {11'b0, chanMasterEn, chanPrio},
            {11'b0, mPrio[27], mPrio[23], mPrio[19], mPrio[15], mPrio[11], mPrio[7], mPrio[3],
             mPrio[26:24], mPrio[22:20], mPrio[18:16], mPrio[14:12], mPrio[10:8], mPrio[6:4], mPrio[2:0]});
      for (int n = 0; n < 7; n++) begin
        check("R2", {8'b0, baseAddrFlat[n*24 +: 24]}, mBase[n]);
        check("R2", blockCtrlFlat[n*32 +: 32], mBlk[n]);
        check("R3", chanCtrlFlat[n*32 +: 32], mCtl[n]);
      end
    end
  end

  task automatic access(logic [6:0] a, logic [1:0] sz, logic wr, logic [31:0] d,
                        logic [6:0] done, string tag);
    @(negedge clk);
    accAddr = a; accSize = sz; accWr = wr; accWdata = d; chanDone = done; curTag = tag;
    @(posedge clk);
    #2;
  endtask

  task automatic expectRead(logic [6:0] a, logic [1:0] sz, logic [31:0] exp, string tag);
    access(a, sz, 1'b0, 32'h0, 7'h0, tag);
    check(tag, accRdata, exp);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    expectRead(7'h74, 2'd2, 32'h0, "R5");
    check("R13", {31'b0, irqOut}, 32'h0);
    expectRead(7'h38, 2'd2, 32'h0, "R3");
    // address width and block control (R2, R1)
    access(7'h00, 2'd2, 1'b1, 32'hFFFF_FFFF, 7'h0, "R2");
    expectRead(7'h00, 2'd2, 32'h00FF_FFFF, "R2");
    access(7'h34, 2'd2, 1'b1, 32'h1234_5678, 7'h0, "R2");
    expectRead(7'h34, 2'd2, 32'h1234_5678, "R1");
    // control mirror and kept bits (R1, R3, R9)
    access(7'h38, 2'd2, 1'b1, 32'hFFFF_FFFF, 7'h0, "R3");
    check("R9", {25'b0, chanRestart}, 32'h08);
    expectRead(7'h3C, 2'd2, 32'h7177_0607, "R1");
    check("R9", {25'b0, chanRestart}, 32'h0);
    // sub-word block control (R10)
    access(7'h35, 2'd0, 1'b1, 32'h0000_00AB, 7'h0, "R10");
    expectRead(7'h34, 2'd2, 32'h1234_AB78, "R10");
    access(7'h36, 2'd1, 1'b1, 32'h0000_BEEF, 7'h0, "R10");
    expectRead(7'h34, 2'd2, 32'hBEEF_AB78, "R10");
    expectRead(7'h37, 2'd0, 32'h0000_00BE, "R10");
    expectRead(7'h36, 2'd1, 32'h0000_BEEF, "R10");
    // sub-word elsewhere acts as shifted word (R11)
    access(7'h10, 2'd2, 1'b1, 32'h00AA_BBCC, 7'h0, "R11");
    access(7'h12, 2'd1, 1'b1, 32'h0000_5A5A, 7'h0, "R11");
    expectRead(7'h10, 2'd2, 32'h005A_0000, "R11");
    expectRead(7'h12, 2'd0, 32'h0000_005A, "R11");
    // priority word (R4)
    access(7'h70, 2'd2, 1'b1, 32'hFFFF_FFFF, 7'h0, "R4");
    expectRead(7'h70, 2'd2, 32'h0FFF_FFFF, "R4");
    check("R4", {25'b0, chanMasterEn}, 32'h7F);
    // constants and ignored writes (R7)
    access(7'h78, 2'd2, 1'b1, 32'h0, 7'h0, "R7");
    access(7'h7C, 2'd2, 1'b1, 32'h0, 7'h0, "R7");
    expectRead(7'h78, 2'd2, 32'h7FE3_58D1, "R7");
    expectRead(7'h7C, 2'd2, 32'h00FF_FFF7, "R7");
    expectRead(7'h70, 2'd2, 32'h0FFF_FFFF, "R7");
    // ordering-table channel forcing (R8)
    access(7'h68, 2'd2, 1'b1, 32'hFFFF_FFFF, 7'h0, "R8");
    check("R9", {25'b0, chanRestart}, 32'h40);
    expectRead(7'h6C, 2'd2, 32'h5100_0002, "R8");
    access(7'h6C, 2'd2, 1'b1, 32'h0, 7'h0, "R8");
    expectRead(7'h68, 2'd2, 32'h0000_0002, "R8");
    // interrupt enable and flag set (R5, R12, R13)
    access(7'h74, 2'd2, 1'b1, 32'h0084_003F, 7'h0, "R5");
    access(7'h00, 2'd2, 1'b0, 32'h0, 7'h04, "R12");
    check("R13", {31'b0, irqOut}, 32'h1);
    expectRead(7'h74, 2'd2, 32'h8484_003F, "R12");
    check("R13", {31'b0, irqOut}, 32'h0);
    access(7'h00, 2'd2, 1'b0, 32'h0, 7'h10, "R12");
    expectRead(7'h74, 2'd2, 32'h8484_003F, "R12");
    // write-one-to-clear (R6)
    access(7'h74, 2'd2, 1'b1, 32'h0084_003F, 7'h0, "R6");
    expectRead(7'h74, 2'd2, 32'h8484_003F, "R6");
    access(7'h74, 2'd2, 1'b1, 32'h0484_003F, 7'h0, "R6");
    expectRead(7'h74, 2'd2, 32'h0084_003F, "R6");
    // set wins over clear (R12)
    access(7'h74, 2'd2, 1'b1, 32'h0484_003F, 7'h04, "R12");
    expectRead(7'h74, 2'd2, 32'h8484_003F, "R12");
    // force raises master flag, reads zero (R5, R13)
    access(7'h74, 2'd2, 1'b1, 32'h0400_0000, 7'h0, "R6");
    expectRead(7'h74, 2'd2, 32'h0, "R6");
    access(7'h74, 2'd2, 1'b1, 32'h0000_8000, 7'h0, "R13");
    check("R13", {31'b0, irqOut}, 32'h1);
    expectRead(7'h74, 2'd2, 32'h8000_0000, "R5");
    check("R13", {31'b0, irqOut}, 32'h0);
    repeat (3) access(7'h74, 2'd2, 1'b0, 32'h0, 7'h0, "R5");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule